// File: doc/BRIEF.md
# Ring Oscillator Pair Frequency Comparator

This block produces one response bit from a challenge by racing two ring oscillators against each other. The challenge picks two different members of an oscillator bank. After a start strobe, the block counts rising edges from each picked oscillator over a window whose length is set in system clock cycles. It then reports which oscillator was faster. The oscillators are free-running signals from outside the clock domain. Each one passes through a synchroniser and an edge detector before it can reach a counter.

The bank holds 2^CW oscillators, where CW is the challenge width. The first index of the pair is the challenge itself. The second index is the challenge plus a fixed offset `PAIR_OFS`, wrapped modulo the bank size. `PAIR_OFS` must not be a multiple of the bank size, so the two indices always differ.

Start, challenge, window length and done are plain control pins with no handshake. A run is requested by pulsing `start` while the block is idle. The result is read in the cycle where `done` is high, or at any later cycle until the next accepted start.

Top module: `ro_pair_cmp`

## Requirements
- R1: Bit i of `osc_in` is oscillator i. A run compares oscillator `challenge` (counter A) against oscillator `(challenge + PAIR_OFS) mod 2^CW` (counter B). This includes the case where the sum wraps past the top of the bank.
- R2: Each counter advances once for each rising edge of its own oscillator inside the window, provided the high and low phases each last at least two clock cycles. Edges on the other oscillators of the bank have no effect on the result.
- R3: A start accepted while idle clears both counters and latches the challenge. Edges that occurred before that start are not counted.
- R4: With W = `win_len` (a value of 0 acts as 1), `done` goes high on the W-th rising clock edge after the edge that samples `start`. It stays high for exactly one cycle.
- R5: `resp` is 1 only when count A is strictly greater than count B.
- R6: `tie` is 1 exactly when the two counts are equal. `resp` and `tie` are never 1 together.
- R7: Each counter stops at 2^CNT_W-1 and does not wrap.
- R8: A start that arrives while a run is in progress is ignored. The challenge pair and the done timing of the current run stay as they were.
- R9: `resp` and `tie` keep their values from the done cycle until the next accepted start.
- R10: After reset, `done` = 0, `resp` = 0 and `tie` = 1, because both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| challenge | input | CW | Selects the oscillator pair |
| start | input | 1 | Begin a measurement; taken only when idle |
| win_len | input | WIN_W | Window length in clock cycles |
| osc_in | input | 2^CW | Asynchronous oscillator bank |
| resp | output | 1 | 1 when oscillator A counted more edges than B |
| tie | output | 1 | Both counts equal |
| done | output | 1 | One-cycle pulse at the end of the window |

## Verification
A wrong pair decode, a counter that wraps or double-counts, or a counter that is not cleared shows up as a wrong `resp`/`tie` value in the very next done cycle. The stimulus therefore uses edge counts chosen so that each of these faults flips the result. A window counter that is off by one, or that re-arms during a run, moves `done` by at least one cycle. The cycle of `done` is checked against the start edge on every run. A restart taken while busy also changes the latched pair, and that fault shows up both in the result and in the timing.

// File: rtl/ro_pair_pkg.sv
package ro_pair_pkg;
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } meas_state_e;
endpackage

// File: rtl/ro_edge_sync.sv
module ro_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise_pulse = sync_q & ~hist_q;
endmodule

// File: rtl/ro_sat_counter.sv
module ro_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (clr)                     count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/ro_window_ctl.sv
module ro_window_ctl
  import ro_pair_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  output logic             accept,
  output logic             busy,
  output logic             done
);
  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  meas_state_e      state_q;
  logic [WIN_W-1:0] left_q;

  assign accept = start && (state_q == MS_IDLE);
  assign busy   = (state_q == MS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      left_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= MS_RUN;
        left_q  <= (win_len == '0) ? ONE : win_len;
      end else if (state_q == MS_RUN) begin
        if (left_q == ONE) begin
          state_q <= MS_IDLE;
          done    <= 1'b1;
        end
        left_q <= left_q - ONE;
      end
    end
  end
endmodule

// File: rtl/ro_pair_cmp.sv
module ro_pair_cmp #(
  parameter int CW       = 3,
  parameter int CNT_W    = 8,
  parameter int WIN_W    = 12,
  parameter int PAIR_OFS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      challenge,
  input  logic               start,
  input  logic [WIN_W-1:0]   win_len,
  input  logic [(1<<CW)-1:0] osc_in,
  output logic               resp,
  output logic               tie,
  output logic               done
);
  localparam int            NOSC   = 1 << CW;
  localparam logic [CW-1:0] OFS_CW = CW'(PAIR_OFS % NOSC);

  logic [NOSC-1:0]  rise_vec;
  logic [CW-1:0]    sel_a_q, sel_b_q;
  logic             accept, busy;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  // one synchroniser and edge detector per oscillator of the bank
  for (genvar gi = 0; gi < NOSC; gi++) begin : g_sync
    ro_edge_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (osc_in[gi]),
      .rise_pulse(rise_vec[gi])
    );
  end

  ro_window_ctl #(.WIN_W(WIN_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .win_len(win_len),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  // pair decode: second index is offset and wraps in CW bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= '0;
      sel_b_q <= OFS_CW;
    end else if (accept) begin
      sel_a_q <= challenge;
      sel_b_q <= challenge + OFS_CW;
    end
  end

  ro_sat_counter #(.CNT_W(CNT_W)) u_cnt_a (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (busy & rise_vec[sel_a_q]),
    .count(cnt_a)
  );

  ro_sat_counter #(.CNT_W(CNT_W)) u_cnt_b (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (busy & rise_vec[sel_b_q]),
    .count(cnt_b)
  );

  assign resp = (cnt_a > cnt_b);
  assign tie  = (cnt_a == cnt_b);
endmodule

// File: rtl/ro_pair_chk.sv
module ro_pair_chk #(
  parameter int CW    = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             resp,
  input logic             tie,
  input logic             busy,
  input logic [CW-1:0]    sel_a,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt_a == '0 && cnt_b == '0));

  a_r6_resp_tie_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp && tie));

  a_r7_sat_a: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_a == CMAX) |=> (cnt_a == CMAX));

  a_r7_sat_b: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_b == CMAX) |=> (cnt_b == CMAX));

  a_r8_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_a));

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(resp) && $stable(tie) && $stable(cnt_a)));
endmodule

bind ro_pair_cmp ro_pair_chk #(.CW(CW), .CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .done (done),
  .resp (resp),
  .tie  (tie),
  .busy (busy),
  .sel_a(sel_a_q),
  .cnt_a(cnt_a),
  .cnt_b(cnt_b)
);

// File: tb/ro_pair_cmp_tb.sv
module ro_pair_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 3;
  localparam int NOSC  = 1 << CW;
  localparam int CNT_W = 8;
  localparam int WIN_W = 12;
  localparam int OFS   = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  typedef struct {
    logic resp;
    logic tie;
    int   exp_cyc;
    int   id;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CW-1:0]    challenge = '0;
  logic             start = 1'b0;
  logic [WIN_W-1:0] win_len = '0;
  logic [NOSC-1:0]  osc_in = '0;
  logic             resp, tie, done;

  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  int   runs_done = 0;
  logic prev_done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ro_pair_cmp #(.CW(CW), .CNT_W(CNT_W), .WIN_W(WIN_W), .PAIR_OFS(OFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .challenge(challenge), .start(start),
    .win_len(win_len), .osc_in(osc_in), .resp(resp), .tie(tie), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check("R4 done longer than one cycle", 1, 0);
      if (done && !prev_done) begin
        if (sb_q.size() == 0) begin
          check("R4 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check($sformatf("R5 resp run %0d", e.id), resp, e.resp);
          check($sformatf("R6 tie run %0d", e.id), tie, e.tie);
          check($sformatf("R4 done cycle run %0d", e.id), cyc, e.exp_cyc);
        end
        runs_done++;
      end
      prev_done <= done;
    end
  end

  // driver: one measurement, with an optional restart while busy (R8)
  task automatic run_case(input int id, input int ch, input int w,
                          input int na, input int nb, input int no, input bit mid);
    int ia, ib, weff, ca, cb, tgt, n;
    exp_t e;
    ia = ch % NOSC;
    ib = (ch + OFS) % NOSC;
    weff = (w == 0) ? 1 : w;
    ca = (na > CMAX) ? CMAX : na;
    cb = (nb > CMAX) ? CMAX : nb;
    n = (na > nb) ? na : nb;
    if (no > n) n = no;
    @(negedge clk);
    challenge = CW'(ch);
    win_len = WIN_W'(w);
    start = 1'b1;
    e.resp = (ca > cb);
    e.tie = (ca == cb);
    e.exp_cyc = cyc + 1 + weff;
    e.id = id;
    tgt = runs_done + 1;
    sb_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (mid) begin
      @(negedge clk);
      challenge = CW'(ch + 3);
      win_len = WIN_W'(5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      logic [NOSC-1:0] pat;
      pat = '0;
      if (i < no) pat = ~'0;
      pat[ia] = (i < na);
      pat[ib] = (i < nb);
      @(negedge clk); osc_in = pat;
      @(negedge clk);
      @(negedge clk); osc_in = '0;
      @(negedge clk);
    end
    wait (runs_done >= tgt);
    repeat (3) @(negedge clk);
    check($sformatf("R9 resp held run %0d", id), resp, e.resp);
    check($sformatf("R9 tie held run %0d", id), tie, e.tie);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 done after reset", done, 0);
    check("R10 resp after reset", resp, 0);
    check("R10 tie after reset", tie, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R5: pair 0/3, A faster
    run_case(1, 0, 40, 5, 3, 0, 0);
    // R1 wrap: pair 6/1, B faster, R2 other oscillators toggling more
    run_case(2, 6, 50, 2, 4, 7, 0);
    // R6 tie with equal edges
    run_case(3, 4, 30, 3, 3, 0, 0);
    // R6 no edges at all
    run_case(4, 1, 12, 0, 0, 0, 0);
    // R3: edges on pair 2/5 while idle, then a clean run
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); osc_in = 8'h24;
      @(negedge clk);
      @(negedge clk); osc_in = '0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    run_case(5, 2, 30, 1, 2, 0, 0);
    // R7 saturation: both clip to max -> tie
    run_case(6, 3, 1300, 300, 260, 0, 0);
    // R7 one clips, the other below max
    run_case(7, 5, 1300, 300, 200, 0, 0);
    // R4 zero window acts as one cycle
    run_case(8, 7, 0, 0, 0, 0, 0);
    // R4 single-cycle window
    run_case(9, 2, 1, 0, 0, 0, 0);
    // R8 restart while busy is ignored
    run_case(10, 2, 40, 1, 4, 0, 1);
    repeat (4) @(negedge clk);
    check("R4 no stray done", sb_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule